// File: doc/BRIEF.md
# Two-Pin Selectable Waveform Generator

This block drives two output pins from a shared time base. The time base is a clock-enable tick arriving at 65536 Hz, which is twice 32768 Hz, so every duration the block produces is a whole number of ticks. Each pin has its own 3-bit source select. The select can hold the pin low, pick one of four square waves (1 Hz, 32 Hz, 64 Hz, 512 Hz), follow a level alarm flag, toggle on each rising edge of that flag, or emit a programmable pulse train.

The pulse train has two settings, a high-time code and a period code. Both pins use the same two codes. Each pin keeps its own pulse counter, and that counter restarts whenever the pin's select changes. All square waves come from one free-running divider, so pins that use the same rate stay in phase. Every output is registered. An output therefore reacts on the clock edge after its inputs change.

Top module: `clkout_gen`

## Requirements
- R1: While `rst` is high, and on the first edge after it, both outputs are 0. The divider, the pulse counters and the alarm-toggle state are all cleared to 0.
- R2: Select code 0 holds the output at 0.
- R3: Select codes 1, 2, 3 and 4 give 50% square waves whose periods are 65536, 2048, 1024 and 128 ticks. Each wave is low for the first half of its period after reset. All of them come from one shared divider, so two pins with the same code give identical outputs.
- R4: Select code 5 outputs a toggle state. The state starts at 0 and inverts on each rising edge of `alarm`. The output shows the new state two clock edges after the rising edge is presented.
- R5: Select code 6 copies `alarm`, delayed by one clock edge.
- R6: Select code 7 gives a pulse train whose high time follows `hi_code`. Codes 0 to 7 give 2048, 1024, 256, 64, 32, 8, 2 and 1 ticks.
- R7: The pulse period follows `per_code`. Codes 0 to 3 give 65536, 32768, 16384 and 8192 ticks.
- R8: `hi_code` and `per_code` are shared by both pins, while each pin has its own select.
- R9: When a pin's select changes to 7, its pulse counter restarts. The output is 1 on the very next edge, and the high phase then runs for its full length.
- R10: With `tick` low, the divider and the pulse counters hold their values, so square-wave and pulse outputs do not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | Time-base enable, one pulse per 1/65536 s |
| alarm | input | 1 | Level alarm flag |
| sel0 | input | 3 | Source select for out0 |
| sel1 | input | 3 | Source select for out1 |
| hi_code | input | 3 | Shared pulse high-time code |
| per_code | input | 2 | Shared pulse period code |
| out0 | output | 1 | Waveform pin 0 |
| out1 | output | 1 | Waveform pin 1 |

## Verification
The bench builds the block with the default `TICK_LOG2` of 16, so all durations are the real tick counts. In long stretches `tick` is held high on every cycle. This lets the full 1 Hz period and the full 8192-tick pulse period complete, so every high-time code can be observed end to end within the cycle budget. Random segments thin out `tick` and vary `alarm`. A stretch with `tick` held low shows that the outputs freeze.

// File: rtl/clkout_pkg.sv
package clkout_pkg;

  typedef enum logic [2:0] {
    SRC_LOW      = 3'd0,
    SRC_SQ_1     = 3'd1,
    SRC_SQ_32    = 3'd2,
    SRC_SQ_64    = 3'd3,
    SRC_SQ_512   = 3'd4,
    SRC_ALM_TOG  = 3'd5,
    SRC_ALM_COPY = 3'd6,
    SRC_PULSE    = 3'd7
  } src_e;

  localparam int BASE_LOG2 = 16;
  localparam int NUM_SQ    = 4;

  // log2 of the high time in ticks at a 2^16 Hz tick rate
  function automatic int hi_shift(input logic [2:0] code);
    case (code)
      3'd0:    return 11;
      3'd1:    return 10;
      3'd2:    return 8;
      3'd3:    return 6;
      3'd4:    return 5;
      3'd5:    return 3;
      3'd6:    return 1;
      default: return 0;
    endcase
  endfunction

endpackage

// File: rtl/clkout_timebase.sv
module clkout_timebase #(
  parameter int TICK_LOG2 = 16
) (
  input  logic                             clk,
  input  logic                             rst,
  input  logic                             tick,
  output logic [clkout_pkg::NUM_SQ-1:0]    sq
);
  logic [TICK_LOG2-1:0] phase_q;

  always_ff @(posedge clk) begin
    if (rst)       phase_q <= '0;
    else if (tick) phase_q <= phase_q + 1'b1;
  end

  // bit n toggles every 2^n ticks, so the wave period is 2^(n+1) ticks
  assign sq[0] = phase_q[TICK_LOG2-1];
  assign sq[1] = phase_q[TICK_LOG2-6];
  assign sq[2] = phase_q[TICK_LOG2-7];
  assign sq[3] = phase_q[TICK_LOG2-10];
endmodule

// File: rtl/clkout_alarm_track.sv
module clkout_alarm_track (
  input  logic clk,
  input  logic rst,
  input  logic alarm,
  output logic tog
);
  logic alarm_d;

  always_ff @(posedge clk) begin
    if (rst) begin
      alarm_d <= 1'b0;
      tog     <= 1'b0;
    end else begin
      alarm_d <= alarm;
      if (alarm && !alarm_d) tog <= ~tog;
    end
  end
endmodule

// File: rtl/clkout_pulse.sv
module clkout_pulse #(
  parameter int TICK_LOG2 = 16
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       tick,
  input  logic [2:0] sel,
  input  logic [2:0] hi_code,
  input  logic [1:0] per_code,
  output logic       level
);
  localparam int BIAS = TICK_LOG2 - clkout_pkg::BASE_LOG2;

  logic [TICK_LOG2-1:0] cnt_q;
  logic [TICK_LOG2-1:0] high_ticks;
  logic [TICK_LOG2-1:0] wrap_mask;
  logic [2:0]           sel_d;
  logic                 restart;

  always_comb begin
    high_ticks = TICK_LOG2'(1) << (clkout_pkg::hi_shift(hi_code) + BIAS);
    wrap_mask  = {TICK_LOG2{1'b1}} >> per_code;
    restart    = (sel != sel_d);
    level      = restart || (cnt_q < high_ticks);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
      sel_d <= '0;
    end else begin
      sel_d <= sel;
      if (restart)   cnt_q <= '0;
      else if (tick) cnt_q <= (cnt_q + 1'b1) & wrap_mask;
    end
  end
endmodule

// File: rtl/clkout_gen.sv
module clkout_gen #(
  parameter int TICK_LOG2 = 16
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       tick,
  input  logic       alarm,
  input  logic [2:0] sel0,
  input  logic [2:0] sel1,
  input  logic [2:0] hi_code,
  input  logic [1:0] per_code,
  output logic       out0,
  output logic       out1
);
  import clkout_pkg::*;

  localparam int NPIN = 2;

  logic [NUM_SQ-1:0] sq;
  logic              tog;
  logic [2:0]        sel_a   [NPIN];
  logic [NPIN-1:0]   pulse_lv;
  logic [NPIN-1:0]   out_q;

  assign sel_a[0] = sel0;
  assign sel_a[1] = sel1;

  clkout_timebase #(.TICK_LOG2(TICK_LOG2)) tb_i (
    .clk(clk), .rst(rst), .tick(tick), .sq(sq)
  );

  clkout_alarm_track alm_i (
    .clk(clk), .rst(rst), .alarm(alarm), .tog(tog)
  );

  for (genvar i = 0; i < NPIN; i++) begin : g_pin
    logic nxt;

    clkout_pulse #(.TICK_LOG2(TICK_LOG2)) pulse_i (
      .clk(clk), .rst(rst), .tick(tick), .sel(sel_a[i]),
      .hi_code(hi_code), .per_code(per_code), .level(pulse_lv[i])
    );

    always_comb begin
      case (src_e'(sel_a[i]))
        SRC_SQ_1:     nxt = sq[0];
        SRC_SQ_32:    nxt = sq[1];
        SRC_SQ_64:    nxt = sq[2];
        SRC_SQ_512:   nxt = sq[3];
        SRC_ALM_TOG:  nxt = tog;
        SRC_ALM_COPY: nxt = alarm;
        SRC_PULSE:    nxt = pulse_lv[i];
        default:      nxt = 1'b0;
      endcase
    end

    always_ff @(posedge clk) begin
      if (rst) out_q[i] <= 1'b0;
      else     out_q[i] <= nxt;
    end
  end

  assign out0 = out_q[0];
  assign out1 = out_q[1];
endmodule

// File: rtl/clkout_gen_chk.sv
module clkout_gen_chk (
  input logic       clk,
  input logic       rst,
  input logic       alarm,
  input logic [2:0] sel0,
  input logic [2:0] sel1,
  input logic       out0,
  input logic       out1
);
  // R1: outputs cleared by reset
  assert_reset_low_R1: assert property (@(posedge clk)
    rst |=> (!out0 && !out1));

  // R2: low source holds the pin at 0
  assert_low_src_R2: assert property (@(posedge clk) disable iff (rst)
    (sel0 == 3'd0) |=> !out0);

  // R3: same square-wave or alarm code on both pins gives the same level
  assert_phase_aligned_R3: assert property (@(posedge clk) disable iff (rst)
    (sel0 == sel1 && sel0 >= 3'd1 && sel0 <= 3'd6) |=> (out0 == out1));

  // R5: copy source follows alarm one edge later
  assert_alarm_copy_R5: assert property (@(posedge clk) disable iff (rst)
    (sel1 == 3'd6) |=> (out1 == $past(alarm)));

  // R9: a change into the pulse source starts in the high phase
  assert_pulse_restart_R9: assert property (@(posedge clk) disable iff (rst)
    (sel0 == 3'd7 && sel0 != $past(sel0)) |=> out0);
endmodule

bind clkout_gen clkout_gen_chk chk_i (
  .clk(clk), .rst(rst), .alarm(alarm), .sel0(sel0), .sel1(sel1),
  .out0(out0), .out1(out1)
);

// File: tb/clkout_gen_tb.sv
module clkout_gen_tb_top;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       tick = 1'b0;
  logic       alarm = 1'b0;
  logic [2:0] sel0 = 3'd0;
  logic [2:0] sel1 = 3'd0;
  logic [2:0] hi_code = 3'd0;
  logic [1:0] per_code = 2'd0;
  logic       out0, out1;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  bit tick_off = 1'b0;

  always #2.5 clk = ~clk;

  clkout_gen dut_i (
    .clk(clk), .rst(rst), .tick(tick), .alarm(alarm), .sel0(sel0), .sel1(sel1),
    .hi_code(hi_code), .per_code(per_code), .out0(out0), .out1(out1)
  );

  // reference state built from the requirements
  logic [15:0] m_phase;
  logic        m_alm_d, m_tog;
  logic [15:0] m_pc   [2];
  logic [2:0]  m_seld [2];
  logic        m_out  [2];

  function automatic int hi_ticks(input logic [2:0] c);
    int t [8] = '{2048, 1024, 256, 64, 32, 8, 2, 1};
    return t[c];
  endfunction

  function automatic int per_ticks(input logic [1:0] c);
    return 65536 >> c;
  endfunction

  function automatic logic sq_level(input int period);
    return ((int'(m_phase) % period) >= period / 2);
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      m_phase = '0; m_alm_d = 0; m_tog = 0;
      for (int i = 0; i < 2; i++) begin
        m_pc[i] = '0; m_seld[i] = '0; m_out[i] = 0;
      end
    end else begin
      for (int i = 0; i < 2; i++) begin
        logic [2:0] s;
        logic rs;
        s  = (i == 0) ? sel0 : sel1;
        rs = (s != m_seld[i]);
        case (s)
          3'd1: m_out[i] = sq_level(65536);
          3'd2: m_out[i] = sq_level(2048);
          3'd3: m_out[i] = sq_level(1024);
          3'd4: m_out[i] = sq_level(128);
          3'd5: m_out[i] = m_tog;
          3'd6: m_out[i] = alarm;
          3'd7: m_out[i] = rs || (int'(m_pc[i]) < hi_ticks(hi_code));
          default: m_out[i] = 0;
        endcase
        if (rs) m_pc[i] = '0;
        else if (tick) m_pc[i] = 16'((int'(m_pc[i]) + 1) % per_ticks(per_code));
        m_seld[i] = s;
      end
      if (alarm && !m_alm_d) m_tog = ~m_tog;
      m_alm_d = alarm;
      if (tick) m_phase = m_phase + 1'b1;
    end
  end

  function automatic string tag(input logic [2:0] s);
    if (rst) return "R1";
    if (tick_off) return "R10";
    case (s)
      3'd0: return "R2";
      3'd5: return "R4";
      3'd6: return "R5";
      3'd7: return "R6 R7 R8 R9";
      default: return "R3";
    endcase
  endfunction

  always @(negedge clk) begin
    if (!done) begin
      checks++;
      if (out0 !== m_out[0]) begin
        errors++;
        $display("FAIL %s out0 actual=%b expected=%b t=%0t", tag(sel0), out0, m_out[0], $time);
      end
      checks++;
      if (out1 !== m_out[1]) begin
        errors++;
        $display("FAIL %s out1 actual=%b expected=%b t=%0t", tag(sel1), out1, m_out[1], $time);
      end
    end
  end

  task automatic run(input int n, input int tick_pct, input int alm_rate);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      tick = (tick_pct >= 100) ? 1'b1 : (($urandom % 100) < tick_pct);
      if (alm_rate > 0 && ($urandom % alm_rate) == 0) alarm = ~alarm;
    end
  endtask

  initial begin
    void'($urandom(32'd20240611));
    repeat (5) @(negedge clk);
    rst = 1'b0;
    // R3: full 1 Hz period on out0, 32 Hz on out1
    sel0 = 3'd1; sel1 = 3'd2;
    run(70000, 100, 0);
    // R6 R7: longest high time with shortest period, then shortest high time
    sel0 = 3'd7; sel1 = 3'd7; hi_code = 3'd0; per_code = 2'd3;
    run(18000, 100, 0);
    hi_code = 3'd7; sel1 = 3'd4;
    run(9000, 100, 0);
    // R10: tick held low freezes divider and pulse counters
    sel0 = 3'd7; sel1 = 3'd1; hi_code = 3'd3;
    tick_off = 1'b1;
    run(2000, 0, 0);
    tick_off = 1'b0;
    // R4 R5: alarm-derived modes with frequent alarm edges
    sel0 = 3'd5; sel1 = 3'd6;
    run(3000, 80, 7);
    // random segments over all codes
    for (int seg = 0; seg < 60; seg++) begin
      sel0 = 3'($urandom); sel1 = 3'($urandom);
      hi_code = 3'($urandom); per_code = 2'($urandom);
      run(700, 50 + int'($urandom % 51), 20);
    end
    // R1: reset in the middle of activity
    sel0 = 3'd5; sel1 = 3'd7;
    rst = 1'b1;
    run(4, 100, 0);
    rst = 1'b0;
    run(2000, 100, 9);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule